// File: doc/BRIEF.md
# Region-Decoding Bus Wait-State Controller

This block sits between a 32-bit processor bus and a set of memory regions that differ in path width and speed. For each request it works out the target region from the address and checks the access against that region's rules. It then holds the requester off for the number of cycles that the region and the access width cost. On the memory side it issues one strobe for each data beat, along with the beat address, the write data and a region code. The memory arrays themselves sit outside the block and are not part of it.

A word access to a 16-bit region becomes two halfword beats. The lower-addressed halfword moves first and the upper one second, which gives little-endian assembly of read data. The display engine drives a contention input. When that input is high in the last cycle of a beat to palette, video or object-attribute memory, the beat is stretched by one cycle, at most once per beat. An access that is illegal finishes in a single cycle. The illegal cases are an unmapped address, a write to a read-only region, a width the region does not take, and size code 3. Such an access raises an error flag, returns zero data and produces no strobe.

The requester raises `req_valid` and holds address, size, write flag and write data stable until `rsp_ready`. The controller accepts a request at a clock edge while idle. A cost of N cycles means that `rsp_ready` is high during the Nth cycle after that edge. Size encoding: 0 is byte, 1 is halfword, 2 is word, and 3 is invalid.

Top module: `memwait_ctrl`

## Requirements
- R1: Address bits 31:28 are ignored. On `mem_region` the region codes are: 1 boot ROM (0x0000000–0x0003FFF), 2 slow RAM (0x2000000–0x203FFFF), 3 fast RAM (0x3000000–0x3007FFF), 4 I/O (0x4000000–0x40003FF), 5 palette (0x5000000–0x50003FF), 6 VRAM (0x6000000–0x6017FFF), 7 object attributes (0x7000000–0x70003FF), 8 cartridge ROM (0x8000000–0xDFFFFFF) and 9 cartridge SRAM (0xE000000–0xE00FFFF). Every other address is unmapped.
- R2: Boot ROM, fast RAM, I/O and object-attribute accesses of any legal width cost 1 cycle, done in one beat.
- R3: Slow RAM costs 3 cycles for a byte or halfword and 6 cycles for a word, the word taking two beats of 3 cycles.
- R4: Palette and VRAM cost 1 cycle for a byte or halfword and 2 cycles for a word, the word taking two beats of 1 cycle.
- R5: Cartridge ROM costs 5 cycles for a byte or halfword and 8 cycles for a word, taken as beats of 5 and 3 cycles. Cartridge SRAM takes byte accesses only, at 5 cycles, and returns `{24'b0, mem_rdata[7:0]}`.
- R6: For palette, VRAM and object-attribute accesses, a high `disp_busy` in a beat's last cycle adds exactly one cycle to that beat, and no beat is stretched more than once.
- R7: A write is an error if it targets boot ROM or cartridge ROM, or if it is a byte write to palette, VRAM or object-attribute memory.
- R8: An error access finishes in 1 cycle with `rsp_err` high and `rsp_rdata` zero, and raises no `mem_strobe`. Unmapped addresses, size 3, and halfword or word accesses to cartridge SRAM are also errors.
- R9: In a two-beat word access, beat 0 uses the request address and carries write bits 15:0 in `mem_wdata[15:0]`. Beat 1 uses the request address plus 2 and carries write bits 31:16. Read data is `{beat-1 mem_rdata[15:0], beat-0 mem_rdata[15:0]}`. A one-beat read returns `mem_rdata` unchanged, except on cartridge SRAM.
- R10: `rsp_ready` is high for exactly one cycle per accepted request. `rsp_rdata` is zero on writes and outside the ready cycle.
- R11: A legal access raises `mem_strobe` once per beat, only in that beat's last cycle, with `mem_we` equal to the write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until ready |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_write | input | 1 | 1 for write |
| req_wdata | input | 32 | Write data |
| disp_busy | input | 1 | Display engine is using video memory |
| rsp_ready | output | 1 | Access complete (one-cycle pulse) |
| rsp_err | output | 1 | Access was rejected |
| rsp_rdata | output | 32 | Read data, valid with ready |
| mem_region | output | 4 | Region code of the current access |
| mem_addr | output | 28 | Beat address |
| mem_strobe | output | 1 | Beat transfer cycle |
| mem_we | output | 1 | Beat is a write |
| mem_wdata | output | 32 | Beat write data |
| mem_rdata | input | 32 | Beat read data from the region |

## Verification
The hardest case to reach is a word access to VRAM or palette memory in which the contention input stays high across both beats. Covering it means confirming that each beat is stretched once and only once, and that the strobes and the assembled halfwords still line up with the stretched timing. The bench sets up this case with directed accesses that hold `disp_busy` high for the whole transfer. Random traffic also draws the contention level at random against region bases in every window, with random upper address nibbles, so stretched and unstretched beats mix across all widths and error cases.

// File: rtl/memwait_pkg.sv
package memwait_pkg;

  typedef enum logic [3:0] {
    RG_NONE = 4'd0,
    RG_BOOT = 4'd1,
    RG_SLOW = 4'd2,
    RG_FAST = 4'd3,
    RG_IO   = 4'd4,
    RG_PAL  = 4'd5,
    RG_VRAM = 4'd6,
    RG_OAM  = 4'd7,
    RG_CART = 4'd8,
    RG_SRAM = 4'd9
  } region_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // window spans inside each 16 MB page
  localparam logic [23:0] SPAN_BOOT = 24'h004000;
  localparam logic [23:0] SPAN_SLOW = 24'h040000;
  localparam logic [23:0] SPAN_FAST = 24'h008000;
  localparam logic [23:0] SPAN_IO   = 24'h000400;
  localparam logic [23:0] SPAN_PAL  = 24'h000400;
  localparam logic [23:0] SPAN_VRAM = 24'h018000;
  localparam logic [23:0] SPAN_OAM  = 24'h000400;
  localparam logic [23:0] SPAN_SRAM = 24'h010000;

endpackage

// File: rtl/memwait_decode.sv
module memwait_decode
  import memwait_pkg::*;
#(
  parameter int AW = 28
) (
  input  logic [AW-1:0] addr_i,
  output region_t       region_o
);

  logic [3:0]  page;
  logic [23:0] off;

  assign page = addr_i[AW-1:AW-4];
  assign off  = addr_i[23:0];

  always_comb begin
    region_o = RG_NONE;
    case (page)
      4'h0: if (off < SPAN_BOOT) region_o = RG_BOOT;
      4'h2: if (off < SPAN_SLOW) region_o = RG_SLOW;
      4'h3: if (off < SPAN_FAST) region_o = RG_FAST;
      4'h4: if (off < SPAN_IO)   region_o = RG_IO;
      4'h5: if (off < SPAN_PAL)  region_o = RG_PAL;
      4'h6: if (off < SPAN_VRAM) region_o = RG_VRAM;
      4'h7: if (off < SPAN_OAM)  region_o = RG_OAM;
      4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: region_o = RG_CART;
      4'hE: if (off < SPAN_SRAM) region_o = RG_SRAM;
      default: region_o = RG_NONE;
    endcase
  end

endmodule

// File: rtl/memwait_rules.sv
module memwait_rules
  import memwait_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SLOW_CYC  = 3,
  parameter int CART_NSEQ = 5,
  parameter int CART_SEQ  = 3,
  parameter int SRAM_CYC  = 5
) (
  input  region_t          region_i,
  input  logic [1:0]       size_i,
  input  logic             write_i,
  output logic             err_o,
  output logic             two_o,
  output logic [CNT_W-1:0] cyc0_o,
  output logic [CNT_W-1:0] cyc1_o,
  output logic             video_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic narrow16;
  logic ro_hit;
  logic byte_wr_bad;
  logic width_bad;

  always_comb begin
    cyc0_o   = ONE;
    cyc1_o   = ONE;
    narrow16 = 1'b0;
    video_o  = 1'b0;
    case (region_i)
      RG_SLOW: begin
        cyc0_o   = CNT_W'(SLOW_CYC);
        cyc1_o   = CNT_W'(SLOW_CYC);
        narrow16 = 1'b1;
      end
      RG_PAL, RG_VRAM: begin
        narrow16 = 1'b1;
        video_o  = 1'b1;
      end
      RG_OAM:  video_o = 1'b1;
      RG_CART: begin
        cyc0_o   = CNT_W'(CART_NSEQ);
        cyc1_o   = CNT_W'(CART_SEQ);
        narrow16 = 1'b1;
      end
      RG_SRAM: cyc0_o = CNT_W'(SRAM_CYC);
      default: ;
    endcase
  end

  assign ro_hit      = write_i && (region_i == RG_BOOT || region_i == RG_CART);
  assign byte_wr_bad = write_i && (size_i == SZ_BYTE) && video_o;
  assign width_bad   = (size_i == 2'd3) || (region_i == RG_SRAM && size_i != SZ_BYTE);
  assign err_o       = (region_i == RG_NONE) || ro_hit || byte_wr_bad || width_bad;
  assign two_o       = narrow16 && (size_i == SZ_WORD) && !err_o;

endmodule

// File: rtl/memwait_seq.sv
module memwait_seq #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             err_i,
  input  logic             two_i,
  input  logic [CNT_W-1:0] cyc0_i,
  input  logic [CNT_W-1:0] cyc1_i,
  input  logic             video_i,
  input  logic             disp_busy_i,
  output logic             busy_o,
  output logic             beat_o,
  output logic             two_o,
  output logic             err_o,
  output logic             strobe_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam int LEN_W   = CNT_W + 2;
  localparam int MAX_LEN = 2 * (2 ** CNT_W) + 2;

  logic             busy_q, busy_d;
  logic             beat_q, beat_d;
  logic             pen_q, pen_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, two_q, video_q;
  logic [CNT_W-1:0] cyc1_q;
  logic             load_en;
  logic             last_cyc, stall, beat_done, final_beat;

  assign load_en    = start_i && !busy_q;
  assign last_cyc   = busy_q && (cnt_q == '0);
  assign stall      = last_cyc && video_q && !err_q && disp_busy_i && !pen_q;
  assign beat_done  = last_cyc && !stall;
  assign final_beat = beat_done && (beat_q || !two_q);

  always_comb begin
    busy_d = busy_q;
    beat_d = beat_q;
    pen_d  = pen_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1;
        beat_d = 1'b0;
        pen_d  = 1'b0;
        cnt_d  = err_i ? '0 : cyc0_i - ONE;
      end
    end else if (stall) begin
      pen_d = 1'b1;
    end else if (beat_done) begin
      if (final_beat) begin
        busy_d = 1'b0;
      end else begin
        beat_d = 1'b1;
        pen_d  = 1'b0;
        cnt_d  = cyc1_q - ONE;
      end
    end else begin
      cnt_d = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= 1'b0;
      pen_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      beat_q <= beat_d;
      pen_q  <= pen_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= 1'b0;
      two_q   <= 1'b0;
      video_q <= 1'b0;
      cyc1_q  <= '0;
    end else if (load_en) begin
      err_q   <= err_i;
      two_q   <= two_i && !err_i;
      video_q <= video_i;
      cyc1_q  <= cyc1_i;
    end
  end

  assign busy_o   = busy_q;
  assign beat_o   = beat_q;
  assign two_o    = two_q;
  assign err_o    = err_q;
  assign strobe_o = beat_done && !err_q;
  assign done_o   = final_beat;

  // occupancy counter for the bounded-latency check
  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (!busy_q) len_q <= '0;
    else             len_q <= len_q + LEN_W'(1);
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R6
  pen_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R8
  err_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && err_i) |=> (done_o && !strobe_o));

  // R6
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(len_q) <= MAX_LEN));

endmodule

// File: rtl/memwait_ctrl.sv
module memwait_ctrl
  import memwait_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int SLOW_CYC  = 3,
  parameter int CART_NSEQ = 5,
  parameter int CART_SEQ  = 3,
  parameter int SRAM_CYC  = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  input  logic [1:0]  req_size,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  input  logic        disp_busy,
  output logic        rsp_ready,
  output logic        rsp_err,
  output logic [31:0] rsp_rdata,
  output logic [3:0]  mem_region,
  output logic [27:0] mem_addr,
  output logic        mem_strobe,
  output logic        mem_we,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata
);

  localparam int AW = 28;
  localparam int DW = 32;
  localparam int HW = DW / 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  region_t          rg_now;
  logic             r_err, r_two, r_video;
  logic [CNT_W-1:0] r_cyc0, r_cyc1;
  logic             busy, beat, two_act, err_act, strobe, done;

  memwait_decode #(.AW(AW)) u_dec (
    .addr_i   (req_addr[AW-1:0]),
    .region_o (rg_now)
  );

  memwait_rules #(
    .CNT_W(CNT_W), .SLOW_CYC(SLOW_CYC), .CART_NSEQ(CART_NSEQ),
    .CART_SEQ(CART_SEQ), .SRAM_CYC(SRAM_CYC)
  ) u_rules (
    .region_i (rg_now),
    .size_i   (req_size),
    .write_i  (req_write),
    .err_o    (r_err),
    .two_o    (r_two),
    .cyc0_o   (r_cyc0),
    .cyc1_o   (r_cyc1),
    .video_o  (r_video)
  );

  memwait_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .start_i     (req_valid),
    .err_i       (r_err),
    .two_i       (r_two),
    .cyc0_i      (r_cyc0),
    .cyc1_i      (r_cyc1),
    .video_i     (r_video),
    .disp_busy_i (disp_busy),
    .busy_o      (busy),
    .beat_o      (beat),
    .two_o       (two_act),
    .err_o       (err_act),
    .strobe_o    (strobe),
    .done_o      (done)
  );

  region_t       region_q;
  logic          write_q;
  logic [HW-1:0] lo_q;
  logic          acc_en, lo_en;

  assign acc_en = req_valid && !busy;
  assign lo_en  = strobe && !beat;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      region_q <= RG_NONE;
      write_q  <= 1'b0;
    end else if (acc_en) begin
      region_q <= rg_now;
      write_q  <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   lo_q <= '0;
    else if (lo_en) lo_q <= mem_rdata[HW-1:0];
  end

  logic [DW-1:0] rd_full;
  always_comb begin
    if (two_act)                rd_full = {mem_rdata[HW-1:0], lo_q};
    else if (region_q == RG_SRAM) rd_full = {{(DW-8){1'b0}}, mem_rdata[7:0]};
    else                        rd_full = mem_rdata;
  end

  always_comb begin
    if (beat)         mem_wdata = {{HW{1'b0}}, req_wdata[DW-1:HW]};
    else if (two_act) mem_wdata = {{HW{1'b0}}, req_wdata[HW-1:0]};
    else              mem_wdata = req_wdata;
  end

  assign mem_addr   = req_addr[AW-1:0] + (beat ? AW'(2) : AW'(0));
  assign mem_region = region_q;
  assign mem_strobe = strobe;
  assign mem_we     = strobe && write_q;
  assign rsp_ready  = done;
  assign rsp_err    = done && err_act;
  assign rsp_rdata  = (done && !err_act && !write_q) ? rd_full : '0;

  // R7
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_we |-> !(mem_region == RG_BOOT || mem_region == RG_CART));

  // R5
  sram_byte_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_strobe && mem_region == RG_SRAM) |-> (req_size == SZ_BYTE));

  // R8
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_err |-> (rsp_ready && rsp_rdata == '0 && !mem_strobe));

  // R7
  video_byte_wr_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_we && (mem_region == RG_PAL || mem_region == RG_VRAM || mem_region == RG_OAM))
      |-> (req_size != SZ_BYTE));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> (!rsp_ready && !mem_strobe));

endmodule

// File: tb/memwait_ctrl_test.sv
module memwait_ctrl_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        req_write;
  logic [31:0] req_wdata;
  logic        disp_busy;
  logic        rsp_ready;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0]  mem_region;
  logic [27:0] mem_addr;
  logic        mem_strobe;
  logic        mem_we;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;

  int n_chk;
  int n_fail;

  memwait_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .disp_busy(disp_busy), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .mem_region(mem_region), .mem_addr(mem_addr),
    .mem_strobe(mem_strobe), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] mem_model(input logic [27:0] a);
    return {~a[15:0], a[15:0] ^ 16'h5A5A};
  endfunction

  assign mem_rdata = mem_model(mem_addr);

  // region codes per R1
  function automatic int exp_region(input logic [27:0] a);
    int p;
    int o;
    p = int'(a[27:24]);
    o = int'(a[23:0]);
    if (p == 0 && o < 'h4000)  return 1;
    if (p == 2 && o < 'h40000) return 2;
    if (p == 3 && o < 'h8000)  return 3;
    if (p == 4 && o < 'h400)   return 4;
    if (p == 5 && o < 'h400)   return 5;
    if (p == 6 && o < 'h18000) return 6;
    if (p == 7 && o < 'h400)   return 7;
    if (p >= 8 && p <= 13)     return 8;
    if (p == 14 && o < 'h10000) return 9;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] addr, input logic [1:0] sz,
                     input bit wr, input logic [31:0] wd, input bit disp);
    int  rg;
    bit  err;
    int  beats;
    int  cyc;
    int  c0;
    int  c1;
    bit  video;
    int  n;
    int  sc;
    bit  seen;
    logic [27:0] a;
    logic [31:0] exp_rd;
    a  = addr[27:0];
    rg = exp_region(a);
    video = (rg == 5 || rg == 6 || rg == 7);
    err = (rg == 0) || (sz == 2'd3) || (wr && (rg == 1 || rg == 8)) ||
          (wr && sz == 2'd0 && video) || (rg == 9 && sz != 2'd0);
    c0 = 1; c1 = 1;
    if (rg == 2) begin c0 = 3; c1 = 3; end
    if (rg == 8) begin c0 = 5; c1 = 3; end
    if (rg == 9) c0 = 5;
    beats = (!err && sz == 2'd2 && (rg == 2 || rg == 5 || rg == 6 || rg == 8)) ? 2 : 1;
    if (err) cyc = 1;
    else cyc = c0 + ((beats == 2) ? c1 : 0) + ((video && disp) ? beats : 0);
    if (err || wr) exp_rd = 32'h0;
    else if (beats == 2) exp_rd = {mem_model(a + 28'd2)[15:0], mem_model(a)[15:0]};
    else if (rg == 9) exp_rd = {24'h0, mem_model(a)[7:0]};
    else exp_rd = mem_model(a);

    @(negedge clk);
    req_addr  = addr;
    req_size  = sz;
    req_write = wr;
    req_wdata = wd;
    disp_busy = disp;
    req_valid = 1'b1;
    n = 0; sc = 0; seen = 0;
    while (!seen && n < 60) begin
      @(negedge clk);
      n++;
      if (mem_strobe) begin
        // R11 R9 R1: beat address, write data, region
        check(mem_we == wr, "R11", "mem_we", {31'h0, mem_we}, {31'h0, wr});
        check(mem_addr == a + ((sc == 1) ? 28'd2 : 28'd0), "R9", "beat addr",
              {4'h0, mem_addr}, {4'h0, a + ((sc == 1) ? 28'd2 : 28'd0)});
        check(int'(mem_region) == rg, "R1", "region", {28'h0, mem_region}, rg);
        if (wr) begin
          logic [31:0] ew;
          if (beats == 2) ew = (sc == 1) ? {16'h0, wd[31:16]} : {16'h0, wd[15:0]};
          else ew = wd;
          check(mem_wdata == ew, "R9", "beat wdata", mem_wdata, ew);
        end
        sc++;
      end
      if (rsp_ready) seen = 1;
    end
    req_valid = 1'b0;
    if (!seen) check(1'b0, "R10", "no ready", 32'(n), 32'(cyc));
    // R2 R3 R4 R5 R6: completion latency
    check(n == cyc, (video && disp) ? "R6" : "R3", "cycles", 32'(n), 32'(cyc));
    // R8 R7: error flag and zero data
    check(rsp_err == err, err ? "R8" : "R7", "err", {31'h0, rsp_err}, {31'h0, err});
    check(rsp_rdata == exp_rd, "R9", "rdata", rsp_rdata, exp_rd);
    // R11 / R8: strobe count
    check(sc == (err ? 0 : beats), err ? "R8" : "R11", "strobes", 32'(sc),
          32'(err ? 0 : beats));
    @(negedge clk);
    // R10: one-cycle ready
    check(!rsp_ready && rsp_rdata == 32'h0, "R10", "ready pulse",
          {31'h0, rsp_ready}, 32'h0);
  endtask

  logic [31:0] bases [10];
  logic [23:0] spans [10];

  initial begin : watchdog
    #(200000 * 10);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    n_chk = 0; n_fail = 0;
    req_valid = 0; req_addr = 0; req_size = 0; req_write = 0;
    req_wdata = 0; disp_busy = 0;
    bases = '{32'h0000000, 32'h2000000, 32'h3000000, 32'h4000000, 32'h5000000,
              32'h6000000, 32'h7000000, 32'h8000000, 32'hE000000, 32'h1000000};
    spans = '{24'h4000, 24'h40000, 24'h8000, 24'h400, 24'h400,
              24'h18000, 24'h400, 24'hFFFFFF, 24'h10000, 24'hFFFFFF};
    rst_n = 0;
    repeat (3) @(negedge clk);
    // reset state
    check(!rsp_ready && !mem_strobe && rsp_rdata == 32'h0, "R10", "reset outputs",
          {30'h0, rsp_ready, mem_strobe}, 32'h0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // directed corner cases
    run(32'hF3000010, 2'd2, 1'b0, 32'h0, 1'b0);        // R1 upper nibble, R2 fast
    run(32'h04000100, 2'd0, 1'b1, 32'hA5, 1'b0);       // R2 I/O byte write
    run(32'h02000020, 2'd2, 1'b0, 32'h0, 1'b0);        // R3 slow word 6
    run(32'h02000020, 2'd1, 1'b1, 32'h1234, 1'b0);     // R3 slow half 3
    run(32'h06000100, 2'd2, 1'b1, 32'hDEADBEEF, 1'b1); // R6 VRAM word, both beats stretched
    run(32'h05000010, 2'd1, 1'b0, 32'h0, 1'b1);        // R6 palette half
    run(32'h07000004, 2'd2, 1'b1, 32'h11223344, 1'b1); // R6 OAM word +1
    run(32'h08000100, 2'd2, 1'b0, 32'h0, 1'b0);        // R5 cart word 8
    run(32'h0D000000, 2'd0, 1'b0, 32'h0, 1'b0);        // R5 cart byte 5
    run(32'h0E000003, 2'd0, 1'b1, 32'h77, 1'b0);       // R5 SRAM byte
    run(32'h0E000004, 2'd1, 1'b0, 32'h0, 1'b0);        // R8 SRAM half rejected
    run(32'h00000100, 2'd2, 1'b1, 32'h5, 1'b0);        // R7 boot write
    run(32'h0A000000, 2'd1, 1'b1, 32'h5, 1'b0);        // R7 cart write
    run(32'h06000001, 2'd0, 1'b1, 32'h5, 1'b1);        // R7 VRAM byte write
    run(32'h01000000, 2'd1, 1'b0, 32'h0, 1'b0);        // R8 unmapped
    run(32'h03000000, 2'd3, 1'b0, 32'h0, 1'b0);        // R8 size 3
    run(32'h06018000, 2'd1, 1'b0, 32'h0, 1'b0);        // R1 VRAM top edge unmapped
    run(32'h00003FFF, 2'd0, 1'b0, 32'h0, 1'b0);        // R1 boot last byte

    // constrained random traffic
    void'($urandom(32'd20240611));
    for (int i = 0; i < 400; i++) begin
      int k;
      logic [31:0] ad;
      k  = int'($urandom % 10);
      ad = bases[k] + ($urandom % (32'(spans[k]) + 32'd2));
      ad[31:28] = 4'($urandom);
      run(ad, 2'($urandom), 1'($urandom), $urandom, 1'($urandom));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule